// File: doc/BRIEF.md
# I2C Target Controller with Host Control Register

This block is an I2C target (slave) running on a fast system clock. It oversamples the SCL and SDA lines, finds start and stop conditions, compares the 7-bit address in the header byte with a configured address, and then receives bytes into a receive register or sends bytes from a transmit register. Both lines are driven open-drain: the block only ever pulls a line low, through an output-enable pin.

A small host register port holds four registers: a control word, the transmit byte, the receive byte and a status word with the receive-full and transmit-empty flags. Through the control word software switches the target on, picks ACK or NAK for received bytes, puts it in standby, turns on clock stretching and the line filter, holds the transmit register cleared, and issues a software reset. Two further control fields (bus-free request, asynchronous wake-up) are stored and read back but drive nothing.

Top module: `i2ct_top`

## Requirements
- R1: After reset the control word reads 0x0000, the status word reads 0x0002 (bit 0 receive-full = 0, bit 1 transmit-empty = 1), and neither line is pulled low.
- R2: Host register map: address 0 control, 1 transmit byte, 2 receive byte, 3 status. Control bits 8:0 are writable and read back (bit 8 transmit clear, 7 enable, 6 software reset, 5 NAK select, 4 bus-free request, 3 stretch enable, 2 filter enable, 1 wake-up detect, 0 active mode); bits 15:9 read 0.
- R3: While the enable bit is 0 the target pulls neither line and never acknowledges.
- R4: A header byte whose upper 7 bits equal `own_addr` is acknowledged (SDA low in the ninth clock); any other header gets no ACK and the target stays off the bus, storing nothing, until the next start.
- R5: While the active-mode bit is 0 (standby) a matching header is answered with NAK.
- R6: A byte written by the controller, MSB first, lands in the receive register and sets receive-full; a host read of address 2 clears receive-full.
- R7: After a received byte the target sends ACK when the NAK select bit is 0 and NAK when it is 1; the bit is sampled at the falling SCL edge that opens the acknowledge clock, so a change during the byte takes effect.
- R8: In a read transfer the target sends the transmit byte MSB first; loading it into the shifter sets transmit-empty, and a host write to address 1 with the clear bit 0 clears transmit-empty. After a controller ACK the next byte is loaded at the following falling SCL edge.
- R9: A read transfer started with no new host write sends the byte left in the transmit register again.
- R10: While the clear bit is 1 the transmit register reads and sends 0x00; a host write to it then leaves both the register and transmit-empty unchanged, and releasing the clear bit leaves transmit-empty unchanged.
- R11: Writing the control word with bit 6 set makes it read exactly 0x0040, releases both lines at once, returns the protocol to idle and resets the status to 0x0002; writing 0 then leaves the control word 0x0000.
- R12: With stretching enabled, when a received byte is still unread at the end of its acknowledge clock the target holds SCL low until the host reads address 2.
- R13: Start and stop are SDA edges while SCL is high; with the filter enabled a one-sample SDA pulse during SCL high is rejected, without it the pulse reads as start plus stop and aborts the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (read of address 2 clears receive-full) |
| host_wdata | input | 9 | Write data (control bits 8:0, transmit byte in 7:0) |
| host_rdata | output | 16 | Read data for the selected register |
| own_addr | input | 7 | Address the target answers to |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench keeps every parameter at its default (two synchronizer stages, 8-bit bytes, 9 control bits) and fixes `own_addr` at 0x2A, with a bus quarter-bit of eight system clocks so that the filter and synchronizer delays stay well inside each SCL phase. That small setting makes an exhaustive sweep of all 128 header addresses affordable, plus sweeps of receive and transmit data values computed arithmetically. It also brings into reach the narrow corners: a NAK-select change in the middle of a byte, a host write landing between two transmitted bytes, stretch release on the host read, and a single-sample SDA pulse with and without the filter.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  // control word bit positions
  localparam int CB_ACTIVE  = 0;
  localparam int CB_WAKE    = 1;
  localparam int CB_FILT    = 2;
  localparam int CB_STRETCH = 3;
  localparam int CB_BFREE   = 4;
  localparam int CB_NAK     = 5;
  localparam int CB_SRST    = 6;
  localparam int CB_EN      = 7;
  localparam int CB_TXCLR   = 8;

  // host register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TX   = 2'd1;
  localparam logic [1:0] A_RX   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_ADDR   = 4'd1,
    ST_AACK   = 4'd2,
    ST_RX     = 4'd3,
    ST_RACK   = 4'd4,
    ST_HOLD   = 4'd5,
    ST_TX     = 4'd6,
    ST_TACK   = 4'd7,
    ST_IGNORE = 4'd8
  } eng_state_e;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  function automatic logic addr_hit(input logic [7:0] hdr, input logic [6:0] own);
    return hdr[7:1] == own;
  endfunction

endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync
  import i2ct_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic filt_en,
  output logic line_o
);
  localparam int TAPS = 3;

  logic [STAGES-1:0] sq;
  logic [TAPS-1:0]   fq;
  logic              synced;

  assign synced = sq[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sq <= '1;
        else        sq <= line_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sq <= '1;
        else        sq <= {sq[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq     <= '1;
      line_o <= 1'b1;
    end else begin
      fq     <= {fq[TAPS-2:0], synced};
      line_o <= filt_en ? maj3(fq) : synced;
    end
  end

endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;

  // R13: SCL steady high during either condition, never both at once
  p_cond_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter int CTRL_W = 9,
  parameter int REG_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              rx_store,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              en_o,
  output logic              srst_o,
  output logic              nak_o,
  output logic              stretch_o,
  output logic              filt_o,
  output logic              active_o
);
  localparam logic [CTRL_W-1:0] SRST_ONLY = {{(CTRL_W-1){1'b0}}, 1'b1} << CB_SRST;

  logic [CTRL_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic              wr_ctrl, wr_tx, rd_rx, tx_clr;

  assign wr_ctrl = host_wr && host_addr == A_CTRL;
  assign wr_tx   = host_wr && host_addr == A_TX;
  assign rd_rx   = host_rd && host_addr == A_RX;
  assign tx_clr  = ctrl_q[CB_TXCLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= host_wdata[CB_SRST] ? SRST_ONLY : host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_q <= '0;
    else if (tx_clr) tx_q <= '0;
    else if (wr_tx)  tx_q <= host_wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tx_empty <= 1'b1;
    else if (srst_o)            tx_empty <= 1'b1;
    else if (wr_tx && !tx_clr)  tx_empty <= 1'b0;
    else if (tx_load)           tx_empty <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_q <= '0;
    else if (rx_store) rx_q <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_full <= 1'b0;
    else if (srst_o)   rx_full <= 1'b0;
    else if (rx_store) rx_full <= 1'b1;
    else if (rd_rx)    rx_full <= 1'b0;
  end

  always_comb begin
    unique case (host_addr)
      A_CTRL:  host_rdata = REG_W'(ctrl_q);
      A_TX:    host_rdata = REG_W'(tx_q);
      A_RX:    host_rdata = REG_W'(rx_q);
      default: host_rdata = REG_W'({tx_empty, rx_full});
    endcase
  end

  assign tx_byte   = tx_q;
  assign en_o      = ctrl_q[CB_EN];
  assign srst_o    = ctrl_q[CB_SRST];
  assign nak_o     = ctrl_q[CB_NAK];
  assign stretch_o = ctrl_q[CB_STRETCH];
  assign filt_o    = ctrl_q[CB_FILT];
  assign active_o  = ctrl_q[CB_ACTIVE];

  // R10: cleared state keeps the byte at zero
  p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> tx_q == '0);
  // R10: a write during the cleared state leaves the empty flag alone
  p_clr_wr_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_clr && !tx_load && !srst_o) |=> $stable(tx_empty));
  // R11: while in software reset no other control bit is set
  p_srst_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> (ctrl_q & ~SRST_ONLY) == '0);
  // R6: a host read of the receive byte empties it
  p_rd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_store && !srst_o) |=> !rx_full);

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              active,
  input  logic              nak_ans,
  input  logic              stretch_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_full,
  output logic              rx_store,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_load,
  output logic              sda_oe,
  output logic              scl_oe
);
  localparam int          CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  eng_state_e        state;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rw_q, acked_q, mack_q;
  logic              ev_ok, hdr_ok, rx_ack;

  // named internal events
  assign ev_ok    = run && !start_det && !stop_det;
  assign hdr_ok   = addr_hit(sh, own_addr) && active;
  assign rx_ack   = active && !nak_ans;
  assign tx_load  = ev_ok && scl_fall &&
                    ((state == ST_AACK && rw_q) || (state == ST_TACK && mack_q));
  assign rx_store = ev_ok && scl_rise && state == ST_RX && cnt == LAST - 1'b1;
  assign rx_byte  = {sh[BYTE_W-2:0], sda};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sh      <= '0;
      cnt     <= '0;
      rw_q    <= 1'b0;
      acked_q <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
      scl_oe  <= 1'b0;
    end else if (!run || stop_det) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST) begin
            if (hdr_ok) begin
              state  <= ST_AACK;
              sda_oe <= 1'b1;
              rw_q   <= sh[0];
            end else begin
              state  <= ST_IGNORE;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              state  <= ST_TX;
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[BYTE_W-1];
            end else begin
              state  <= ST_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST) begin
            state   <= ST_RACK;
            sda_oe  <= rx_ack;
            acked_q <= rx_ack;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (!acked_q) begin
              state <= ST_IGNORE;
            end else if (stretch_en && rx_full) begin
              state  <= ST_HOLD;
              scl_oe <= 1'b1;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_HOLD: begin
          if (!rx_full || !stretch_en) begin
            state  <= ST_RX;
            scl_oe <= 1'b0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST) begin
              state  <= ST_TACK;
              sda_oe <= 1'b0;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[BYTE_W-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            mack_q <= ~sda;
          end else if (scl_fall) begin
            cnt <= '0;
            if (mack_q) begin
              state  <= ST_TX;
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[BYTE_W-1];
            end else begin
              state  <= ST_IGNORE;
              sda_oe <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3: a disabled or reset target leaves both lines alone
  p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sda_oe && !scl_oe));
  // R4: a target that lost the address never drives SDA
  p_ignore_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !sda_oe);
  // R5: an acknowledge only comes from active mode
  p_standby_nak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && (state == ST_AACK || state == ST_RACK)) |-> $past(active));
  // R7: a data ACK follows the NAK select sampled at that edge
  p_ack_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state == ST_RACK) |-> $past(!nak_ans));
  // R12: SCL is only grabbed for an unread byte with stretching on
  p_stretch_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> ($past(rx_full) && $past(stretch_en)));

endmodule

// File: rtl/i2ct_top.sv
module i2ct_top
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int CTRL_W      = 9,
  parameter int REG_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int LINES = 2;

  logic [LINES-1:0]  raw, clean;
  logic              en, srst, nak, stretch, filt, active, run;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              rx_store, tx_load, rx_full, tx_empty;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  assign raw = {sda_i, scl_i};
  assign run = en && !srst;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (raw[g]),
        .filt_en (filt),
        .line_o  (clean[g])
      );
    end
  endgenerate

  i2ct_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (clean[0]),
    .sda       (clean[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2ct_regs #(.CTRL_W(CTRL_W), .REG_W(REG_W), .BYTE_W(BYTE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rx_store   (rx_store),
    .rx_byte    (rx_byte),
    .tx_load    (tx_load),
    .tx_byte    (tx_byte),
    .rx_full    (rx_full),
    .tx_empty   (tx_empty),
    .en_o       (en),
    .srst_o     (srst),
    .nak_o      (nak),
    .stretch_o  (stretch),
    .filt_o     (filt),
    .active_o   (active)
  );

  i2ct_engine #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .active     (active),
    .nak_ans    (nak),
    .stretch_en (stretch),
    .own_addr   (own_addr),
    .sda        (clean[1]),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .tx_byte    (tx_byte),
    .rx_full    (rx_full),
    .rx_store   (rx_store),
    .rx_byte    (rx_byte),
    .tx_load    (tx_load),
    .sda_oe     (sda_oe),
    .scl_oe     (scl_oe)
  );

  // R8: the empty flag rises only after a load into the shifter
  p_empty_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_empty) && !$past(srst)) |-> $past(tx_load));

endmodule

// File: tb/test_i2ct_top.sv
module test_i2ct_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [8:0]  host_wdata = '0;
  logic [15:0] host_rdata;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        scl_oe, sda_oe;
  logic        scl_w, sda_w;
  int          checks = 0;
  int          errors = 0;

  assign scl_w = scl_m & ~scl_oe;
  assign sda_w = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2ct_top i_i2ct_top (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .own_addr(OWN), .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic m_start;
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait (scl_w == 1'b1); wait_clk(2*Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic m_bit_out(input logic b);
    sda_m = b; wait_clk(Q);
    scl_m = 1'b1; wait (scl_w == 1'b1); wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic m_bit_glitch;
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait (scl_w == 1'b1); wait_clk(Q);
    sda_m = 1'b0; wait_clk(1);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic m_bit_in(output logic b);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait (scl_w == 1'b1); wait_clk(Q);
    b = sda_w; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic m_write_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(x);
    ack = ~x;
  endtask

  task automatic m_read_byte(output logic [7:0] d, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      m_bit_in(x);
      d[i] = x;
    end
    m_bit_out(~give_ack);
  endtask

  // one write frame: header plus one data byte
  task automatic frame_write(input logic [7:0] d, output logic hack, output logic dack);
    m_start;
    m_write_byte({OWN, 1'b0}, hack);
    m_write_byte(d, dack);
    m_stop;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic        hack, dack, ack2;
    logic [7:0]  b1, b2, d;

    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    host_read(2'd0, rd); chk("R1 ctrl", rd, 16'h0000);
    host_read(2'd3, rd); chk("R1 status", rd, 16'h0002);
    chk("R1 lines", {14'd0, scl_oe, sda_oe}, 16'h0000);

    // R2 register map and read-back
    host_write(2'd0, 9'h1BF); host_read(2'd0, rd); chk("R2 ctrl all but srst", rd, 16'h01BF);
    host_write(2'd0, 9'h012); host_read(2'd0, rd); chk("R2 ctrl inert bits", rd, 16'h0012);
    host_write(2'd0, 9'h081); host_read(2'd0, rd); chk("R2 ctrl run", rd, 16'h0081);

    // R4 sweep of every header address
    for (int a = 0; a < 128; a++) begin
      m_start;
      m_write_byte({7'(a), 1'b0}, hack);
      m_stop;
      chk($sformatf("R4 header %0d", a), {15'd0, hack}, {15'd0, (7'(a) == OWN)});
    end
    // R4 mismatch: the following byte is neither acknowledged nor stored
    m_start;
    m_write_byte({7'h55, 1'b0}, hack);
    m_write_byte(8'h00, dack);
    m_stop;
    chk("R4 mismatch data ack", {15'd0, dack}, 16'h0000);
    host_read(2'd3, rd); chk("R4 nothing stored", rd, 16'h0002);

    // R6 receive sweep
    for (int i = 0; i < 24; i++) begin
      d = 8'(i * 53 + 7);
      frame_write(d, hack, dack);
      chk("R6 data ack", {14'd0, hack, dack}, 16'h0003);
      host_read(2'd3, rd); chk("R6 full set", rd & 16'h1, 16'h0001);
      host_read(2'd2, rd); chk("R6 rx byte", rd, {8'd0, d});
      host_read(2'd3, rd); chk("R6 full cleared", rd & 16'h1, 16'h0000);
    end

    // R7 NAK select set before the byte
    host_write(2'd0, 9'h0A1);
    frame_write(8'h66, hack, dack);
    chk("R7 nak static", {14'd0, hack, dack}, 16'h0002);
    host_read(2'd2, rd); chk("R7 byte still stored", rd, 16'h0066);
    // R7 NAK select changed in the middle of the byte
    host_write(2'd0, 9'h081);
    m_start;
    m_write_byte({OWN, 1'b0}, hack);
    fork
      m_write_byte(8'h99, dack);
      begin wait_clk(6*4*Q); host_write(2'd0, 9'h0A1); end
    join
    m_stop;
    chk("R7 nak late", {15'd0, dack}, 16'h0000);
    host_write(2'd0, 9'h081);
    host_read(2'd2, rd);

    // R5 standby answers NAK
    host_write(2'd0, 9'h080);
    m_start; m_write_byte({OWN, 1'b0}, hack); m_stop;
    chk("R5 standby header", {15'd0, hack}, 16'h0000);

    // R3 disabled
    host_write(2'd0, 9'h001);
    m_start; m_write_byte({OWN, 1'b0}, hack); m_stop;
    chk("R3 disabled header", {15'd0, hack}, 16'h0000);
    chk("R3 lines idle", {14'd0, scl_oe, sda_oe}, 16'h0000);
    host_write(2'd0, 9'h081);

    // R8 transmit sweep with a host write between bytes
    for (int i = 0; i < 6; i++) begin
      b1 = 8'(i * 71 + 5);
      host_write(2'd1, {1'b0, b1});
      host_read(2'd3, rd); chk("R8 write clears empty", rd & 16'h2, 16'h0000);
      m_start;
      m_write_byte({OWN, 1'b1}, hack);
      chk("R8 read header ack", {15'd0, hack}, 16'h0001);
      fork
        m_read_byte(d, 1'b1);
        begin wait_clk(4*4*Q); host_write(2'd1, {1'b0, ~b1}); end
      join
      m_read_byte(b2, 1'b0);
      m_stop;
      chk("R8 first byte", {8'd0, d}, {8'd0, b1});
      chk("R8 second byte", {8'd0, b2}, {8'd0, ~b1});
      host_read(2'd3, rd); chk("R8 empty after load", rd & 16'h2, 16'h0002);
      // R9 stale byte goes out again
      m_start;
      m_write_byte({OWN, 1'b1}, hack);
      m_read_byte(d, 1'b0);
      m_stop;
      chk("R9 stale byte", {8'd0, d}, {8'd0, ~b1});
    end

    // R10 cleared transmit register
    host_write(2'd1, 9'h03C);
    host_write(2'd0, 9'h181);
    host_read(2'd1, rd); chk("R10 cleared reads zero", rd, 16'h0000);
    host_read(2'd3, rd); chk("R10 set clear keeps empty", rd & 16'h2, 16'h0000);
    m_start; m_write_byte({OWN, 1'b1}, hack); m_read_byte(d, 1'b0); m_stop;
    chk("R10 sends zero", {8'd0, d}, 16'h0000);
    host_read(2'd3, rd); chk("R10 load sets empty", rd & 16'h2, 16'h0002);
    host_write(2'd1, 9'h077);
    host_read(2'd3, rd); chk("R10 write keeps empty", rd & 16'h2, 16'h0002);
    host_read(2'd1, rd); chk("R10 write ignored", rd, 16'h0000);
    host_write(2'd0, 9'h081);
    host_read(2'd3, rd); chk("R10 release keeps empty", rd & 16'h2, 16'h0002);
    host_read(2'd1, rd); chk("R10 released zero", rd, 16'h0000);

    // R12 clock stretching
    host_write(2'd0, 9'h089);
    m_start;
    m_write_byte({OWN, 1'b0}, hack);
    fork
      begin
        m_write_byte(8'h11, dack);
        m_write_byte(8'h22, ack2);
        m_stop;
      end
      begin
        wait (scl_oe == 1'b1);
        wait_clk(200);
        chk("R12 held low", {14'd0, scl_oe, scl_w}, 16'h0002);
        host_read(2'd2, rd); chk("R12 first byte", rd, 16'h0011);
        wait_clk(10);
        chk("R12 released", {15'd0, scl_oe}, 16'h0000);
        wait (scl_oe == 1'b1);
        host_read(2'd2, rd); chk("R12 second byte", rd, 16'h0022);
      end
    join
    chk("R12 acks", {14'd0, dack, ack2}, 16'h0003);

    // R11 software reset in the middle of a transmit
    host_write(2'd0, 9'h081);
    host_write(2'd1, 9'h000);
    m_start;
    m_write_byte({OWN, 1'b1}, hack);
    chk("R11 slave driving", {15'd0, sda_oe}, 16'h0001);
    host_write(2'd0, 9'h1FF);
    host_read(2'd0, rd); chk("R11 only reset bit", rd, 16'h0040);
    chk("R11 lines released", {14'd0, scl_oe, sda_oe}, 16'h0000);
    host_read(2'd3, rd); chk("R11 status", rd, 16'h0002);
    host_write(2'd0, 9'h000);
    host_read(2'd0, rd); chk("R11 released ctrl", rd, 16'h0000);
    m_stop;
    host_write(2'd0, 9'h081);
    frame_write(8'h5C, hack, dack);
    chk("R11 back to normal", {14'd0, hack, dack}, 16'h0003);
    host_read(2'd2, rd);

    // R13 filter on: single-sample pulse is rejected
    host_write(2'd0, 9'h085);
    m_start;
    m_write_byte({OWN, 1'b0}, hack);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) m_bit_glitch; else m_bit_out(1'b1);
    end
    m_bit_in(b1[0]);
    m_stop;
    chk("R13 filtered ack", {15'd0, ~b1[0]}, 16'h0001);
    host_read(2'd2, rd); chk("R13 filtered byte", rd, 16'h00FF);
    // R13 filter off: the same pulse aborts the transfer
    host_write(2'd0, 9'h081);
    m_start;
    m_write_byte({OWN, 1'b0}, hack);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) m_bit_glitch; else m_bit_out(1'b1);
    end
    m_bit_in(b1[0]);
    m_stop;
    chk("R13 unfiltered abort", {15'd0, ~b1[0]}, 16'h0000);
    host_read(2'd3, rd); chk("R13 nothing stored", rd & 16'h1, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule